// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the memory work needed to enter an interrupt handler on a 16-bit segmented processor. The interrupt type number must already be chosen. A one-cycle `start` pulse hands it that 8-bit type and the current processor context: the flags word, the code segment, the instruction pointer, the stack segment and the stack pointer.

The block writes three words onto a stack that grows downward. It then reads a two-word handler pointer from a vector table held in segment zero. When the sequence ends it presents the handler's code segment and instruction pointer, the flags with the interrupt-enable and trap bits cleared, and the final stack pointer, together with a one-cycle `done` pulse.

All memory traffic uses a single word-wide request/acknowledge port carrying 20-bit physical addresses. The physical address is segment × 16 + offset, truncated to 20 bits. Stack offsets wrap modulo 2^16 before that sum is formed.

Top module: `int_entry_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are low, and `new_cs_o`, `new_ip_o`, `new_flags_o` and `new_sp_o` are zero.
- R2: A `start_i` pulse while idle captures `type_i`, `flags_i`, `cs_i`, `ip_i`, `ss_i` and `sp_i`. `busy_o` is high from the next cycle through the cycle in which `done_o` is high, and is low in the cycle after that.
- R3: The block makes exactly three write requests (`mem_we_o`=1), in this order: flags, then CS, then IP. The k-th write (k = 1, 2, 3) goes to physical address ss×16 + ((sp − 2k) mod 2^16), taken mod 2^20.
- R4: While `mem_req_o` is high and `mem_ack_i` is low, the next cycle keeps `mem_req_o` high and keeps `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged. An acknowledge may come in the same cycle the request first appears.
- R5: After the three writes, the block makes two read requests (`mem_we_o`=0). The first reads the handler offset at physical address type×4. The second reads the handler segment at type×4+2. Each read word is taken from `mem_rdata_i` in the cycle its acknowledge is high.
- R6: `done_o` is high for exactly one cycle. `new_cs_o` and `new_ip_o` change only in a cycle where `done_o` is high. In that cycle they equal the segment word and the offset word that were read.
- R7: `new_flags_o` equals the captured flags with bit 9 (interrupt enable) and bit 8 (trap) cleared. All other bits keep their captured values.
- R8: `new_sp_o` equals (sp − 6) mod 2^16 when `done_o` is high.
- R9: A `start_i` pulse while `busy_o` is high, including the cycle in which `done_o` is high, has no effect. No further memory request is made, and the running sequence's addresses, data and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an entry sequence |
| type_i | input | 8 | Interrupt type number |
| flags_i | input | 16 | Current flags word |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| ss_i | input | 16 | Stack segment |
| sp_i | input | 16 | Stack pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Physical word address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_cs_o | output | 16 | Handler code segment |
| new_ip_o | output | 16 | Handler instruction pointer |
| new_flags_o | output | 16 | Flags with IF and TF cleared |
| new_sp_o | output | 16 | Stack pointer after the pushes |

## Verification
Two events can land in the same cycle. The first is an acknowledge arriving in the cycle its request first rises. The bench's memory model is set to zero wait states on every third type, and a request that moved or advanced early would then show up as a wrong or missing transfer in the log. The second is a new start arriving in the completion cycle. The bench pulses `start_i` with different operands exactly when `done_o` is seen, then requires `busy_o` and `mem_req_o` to be low in the following cycle. The bench also requires the five logged transfers and the results to match the first sequence.

// File: rtl/ies_pkg.sv
package ies_pkg;
    localparam int WORD_W    = 16;
    localparam int TYPE_W    = 8;
    localparam int ADDR_W    = 20;
    localparam int SEG_SHIFT = 4;
    localparam int ENTRY_LG2 = 2;
    localparam int IF_POS    = 9;
    localparam int TF_POS    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_RD_OFF,
        ST_RD_SEG,
        ST_DONE
    } ies_state_e;

    typedef struct packed {
        ies_state_e          state;
        logic [TYPE_W-1:0]   vtype;
        logic [WORD_W-1:0]   flags;
        logic [WORD_W-1:0]   cs;
        logic [WORD_W-1:0]   ip;
        logic [WORD_W-1:0]   ss;
        logic [WORD_W-1:0]   sp;
        logic [WORD_W-1:0]   off_tmp;
        logic [WORD_W-1:0]   new_cs;
        logic [WORD_W-1:0]   new_ip;
        logic [WORD_W-1:0]   new_flags;
        logic [WORD_W-1:0]   new_sp;
    } ies_regs_t;
endpackage

// File: rtl/ies_phys_addr.sv
module ies_phys_addr #(
    parameter int WORD_W    = ies_pkg::WORD_W,
    parameter int ADDR_W    = ies_pkg::ADDR_W,
    parameter int SEG_SHIFT = ies_pkg::SEG_SHIFT
) (
    input  logic [WORD_W-1:0] seg_i,
    input  logic [WORD_W-1:0] off_i,
    output logic [ADDR_W-1:0] phys_o
);
    logic [ADDR_W-1:0] seg_ext;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        seg_ext = ADDR_W'(seg_i) << SEG_SHIFT;
        off_ext = ADDR_W'(off_i);
        phys_o  = seg_ext + off_ext;
    end
endmodule

// File: rtl/ies_flag_clear.sv
module ies_flag_clear #(
    parameter int WORD_W = ies_pkg::WORD_W,
    parameter int IF_POS = ies_pkg::IF_POS,
    parameter int TF_POS = ies_pkg::TF_POS
) (
    input  logic [WORD_W-1:0] flags_i,
    output logic [WORD_W-1:0] flags_o
);
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b == IF_POS || b == TF_POS) begin : g_clr
            assign flags_o[b] = 1'b0;
        end else begin : g_keep
            assign flags_o[b] = flags_i[b];
        end
    end
endmodule

// File: rtl/ies_vec_offset.sv
module ies_vec_offset #(
    parameter int TYPE_W    = ies_pkg::TYPE_W,
    parameter int WORD_W    = ies_pkg::WORD_W,
    parameter int ENTRY_LG2 = ies_pkg::ENTRY_LG2,
    parameter bit HI_WORD   = 1'b0
) (
    input  logic [TYPE_W-1:0] type_i,
    output logic [WORD_W-1:0] off_o
);
    localparam logic [WORD_W-1:0] WORD_BYTES = WORD_W'(WORD_W / 8);

    logic [WORD_W-1:0] base;

    always_comb begin
        base = WORD_W'(type_i) << ENTRY_LG2;
        if (HI_WORD) begin
            off_o = base + WORD_BYTES;
        end else begin
            off_o = base;
        end
    end
endmodule

// File: rtl/ies_fsm.sv
module ies_fsm
    import ies_pkg::*;
#(
    parameter int WORD_W = ies_pkg::WORD_W,
    parameter int TYPE_W = ies_pkg::TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TYPE_W-1:0] type_i,
    input  logic [WORD_W-1:0] flags_i,
    input  logic [WORD_W-1:0] cs_i,
    input  logic [WORD_W-1:0] ip_i,
    input  logic [WORD_W-1:0] ss_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic [WORD_W-1:0] vec_lo_i,
    input  logic [WORD_W-1:0] vec_hi_i,
    input  logic [WORD_W-1:0] masked_flags_i,
    input  logic              ack_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              req_o,
    output logic              we_o,
    output logic [WORD_W-1:0] seg_o,
    output logic [WORD_W-1:0] off_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic [TYPE_W-1:0] vtype_o,
    output logic [WORD_W-1:0] saved_flags_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] new_cs_o,
    output logic [WORD_W-1:0] new_ip_o,
    output logic [WORD_W-1:0] new_flags_o,
    output logic [WORD_W-1:0] new_sp_o
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

    ies_regs_t r_d, r_q;
    logic [WORD_W-1:0] sp_dec;

    always_comb begin
        r_d     = r_q;
        req_o   = 1'b0;
        we_o    = 1'b0;
        seg_o   = '0;
        off_o   = '0;
        wdata_o = '0;
        sp_dec  = r_q.sp - STEP;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.vtype = type_i;
                    r_d.flags = flags_i;
                    r_d.cs    = cs_i;
                    r_d.ip    = ip_i;
                    r_d.ss    = ss_i;
                    r_d.sp    = sp_i;
                    r_d.state = ST_PUSH_FL;
                end
            end
            ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: begin
                req_o = 1'b1;
                we_o  = 1'b1;
                seg_o = r_q.ss;
                off_o = sp_dec;
                case (r_q.state)
                    ST_PUSH_FL: wdata_o = r_q.flags;
                    ST_PUSH_CS: wdata_o = r_q.cs;
                    default:    wdata_o = r_q.ip;
                endcase
                if (ack_i) begin
                    r_d.sp = sp_dec;
                    case (r_q.state)
                        ST_PUSH_FL: r_d.state = ST_PUSH_CS;
                        ST_PUSH_CS: r_d.state = ST_PUSH_IP;
                        default:    r_d.state = ST_RD_OFF;
                    endcase
                end
            end
            ST_RD_OFF: begin
                req_o = 1'b1;
                off_o = vec_lo_i;
                if (ack_i) begin
                    r_d.off_tmp = rdata_i;
                    r_d.state   = ST_RD_SEG;
                end
            end
            ST_RD_SEG: begin
                req_o = 1'b1;
                off_o = vec_hi_i;
                if (ack_i) begin
                    r_d.new_cs    = rdata_i;
                    r_d.new_ip    = r_q.off_tmp;
                    r_d.new_flags = masked_flags_i;
                    r_d.new_sp    = r_q.sp;
                    r_d.state     = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign vtype_o       = r_q.vtype;
    assign saved_flags_o = r_q.flags;
    assign busy_o        = (r_q.state != ST_IDLE);
    assign done_o        = (r_q.state == ST_DONE);
    assign new_cs_o      = r_q.new_cs;
    assign new_ip_o      = r_q.new_ip;
    assign new_flags_o   = r_q.new_flags;
    assign new_sp_o      = r_q.new_sp;
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
    import ies_pkg::*;
#(
    parameter int WORD_W    = ies_pkg::WORD_W,
    parameter int TYPE_W    = ies_pkg::TYPE_W,
    parameter int ADDR_W    = ies_pkg::ADDR_W,
    parameter int SEG_SHIFT = ies_pkg::SEG_SHIFT,
    parameter int ENTRY_LG2 = ies_pkg::ENTRY_LG2,
    parameter int IF_POS    = ies_pkg::IF_POS,
    parameter int TF_POS    = ies_pkg::TF_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TYPE_W-1:0] type_i,
    input  logic [WORD_W-1:0] flags_i,
    input  logic [WORD_W-1:0] cs_i,
    input  logic [WORD_W-1:0] ip_i,
    input  logic [WORD_W-1:0] ss_i,
    input  logic [WORD_W-1:0] sp_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] new_cs_o,
    output logic [WORD_W-1:0] new_ip_o,
    output logic [WORD_W-1:0] new_flags_o,
    output logic [WORD_W-1:0] new_sp_o
);
    logic [WORD_W-1:0] seg_w, off_w, vec_lo, vec_hi, saved_flags, masked_flags;
    logic [TYPE_W-1:0] vtype;

    ies_vec_offset #(.TYPE_W(TYPE_W), .WORD_W(WORD_W), .ENTRY_LG2(ENTRY_LG2), .HI_WORD(1'b0))
        u_vec_lo (.type_i(vtype), .off_o(vec_lo));

    ies_vec_offset #(.TYPE_W(TYPE_W), .WORD_W(WORD_W), .ENTRY_LG2(ENTRY_LG2), .HI_WORD(1'b1))
        u_vec_hi (.type_i(vtype), .off_o(vec_hi));

    ies_flag_clear #(.WORD_W(WORD_W), .IF_POS(IF_POS), .TF_POS(TF_POS))
        u_flags (.flags_i(saved_flags), .flags_o(masked_flags));

    ies_phys_addr #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT))
        u_addr (.seg_i(seg_w), .off_i(off_w), .phys_o(mem_addr_o));

    ies_fsm #(.WORD_W(WORD_W), .TYPE_W(TYPE_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .type_i         (type_i),
        .flags_i        (flags_i),
        .cs_i           (cs_i),
        .ip_i           (ip_i),
        .ss_i           (ss_i),
        .sp_i           (sp_i),
        .vec_lo_i       (vec_lo),
        .vec_hi_i       (vec_hi),
        .masked_flags_i (masked_flags),
        .ack_i          (mem_ack_i),
        .rdata_i        (mem_rdata_i),
        .req_o          (mem_req_o),
        .we_o           (mem_we_o),
        .seg_o          (seg_w),
        .off_o          (off_w),
        .wdata_o        (mem_wdata_o),
        .vtype_o        (vtype),
        .saved_flags_o  (saved_flags),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .new_cs_o       (new_cs_o),
        .new_ip_o       (new_ip_o),
        .new_flags_o    (new_flags_o),
        .new_sp_o       (new_sp_o)
    );
endmodule

// File: rtl/ies_checker.sv
module ies_checker #(
    parameter int WORD_W = ies_pkg::WORD_W,
    parameter int ADDR_W = ies_pkg::ADDR_W,
    parameter int IF_POS = ies_pkg::IF_POS,
    parameter int TF_POS = ies_pkg::TF_POS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [WORD_W-1:0] mem_wdata_o,
    input logic              mem_ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] new_cs_o,
    input logic [WORD_W-1:0] new_ip_o,
    input logic [WORD_W-1:0] new_flags_o
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !done_o));

    assert_done_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_handler_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(new_cs_o) && $stable(new_ip_o)));

    assert_flags_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!new_flags_o[IF_POS] && !new_flags_o[TF_POS]));

    assert_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !mem_req_o));
endmodule

bind int_entry_seq ies_checker #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .IF_POS(IF_POS), .TF_POS(TF_POS)
) u_ies_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .new_cs_o    (new_cs_o),
    .new_ip_o    (new_ip_o),
    .new_flags_o (new_flags_o)
);

// File: tb/int_entry_seq_tb.sv
module int_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  type_i = '0;
    logic [15:0] flags_i = '0, cs_i = '0, ip_i = '0, ss_i = '0, sp_i = '0;
    logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
    logic [19:0] mem_addr_o;
    logic [15:0] mem_wdata_o, mem_rdata_i;
    logic        busy_o, done_o;
    logic [15:0] new_cs_o, new_ip_o, new_flags_o, new_sp_o;

    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    int_entry_seq u_dut (.*);

    function automatic logic [15:0] mem_val(input logic [19:0] a);
        return (a[15:0] * 16'd3) ^ {a[19:16], 12'h5A0};
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
        return ({4'b0, seg} << 4) + {4'b0, off};
    endfunction

    assign mem_rdata_i = mem_val(mem_addr_o);

    // memory model and transfer log
    int          wait_cfg = 0;
    int          wcnt = 0;
    logic [19:0] log_addr [0:7];
    logic [15:0] log_data [0:7];
    logic        log_we   [0:7];
    int          log_n = 0;
    logic        pend = 1'b0;
    logic [19:0] p_addr;
    logic [15:0] p_data;
    logic        p_we;
    int          hold_err = 0;

    always @(negedge clk) begin
        if (pend && mem_req_o &&
            (mem_addr_o != p_addr || mem_wdata_o != p_data || mem_we_o != p_we))
            hold_err++;
        if (pend && !mem_req_o) hold_err++;
        if (mem_req_o) begin
            if (wcnt >= wait_cfg) begin
                mem_ack_i = 1'b1;
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr_o;
                    log_data[log_n] = mem_we_o ? mem_wdata_o : mem_rdata_i;
                    log_we[log_n]   = mem_we_o;
                end
                log_n++;
                wcnt = 0;
                pend = 1'b0;
            end else begin
                mem_ack_i = 1'b0;
                wcnt++;
                pend   = 1'b1;
                p_addr = mem_addr_o;
                p_data = mem_wdata_o;
                p_we   = mem_we_o;
            end
        end else begin
            mem_ack_i = 1'b0;
            pend = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [15:0] prev_cs = '0, prev_ip = '0;

    task automatic run_seq(input logic [7:0] t, input logic [15:0] fl, input logic [15:0] cs,
                           input logic [15:0] ip, input logic [15:0] ss, input logic [15:0] sp,
                           input int wc, input int inject);
        int cyc;
        int unstable;
        logic [19:0] ea [0:4];
        logic [15:0] ed [0:4];
        logic        ew [0:4];
        wait_cfg = wc;
        hold_err = 0;
        @(negedge clk);
        log_n = 0;
        type_i = t; flags_i = fl; cs_i = cs; ip_i = ip; ss_i = ss; sp_i = sp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        type_i = ~t; flags_i = ~fl; cs_i = ~cs; ip_i = ~ip; ss_i = ~ss; sp_i = sp + 16'd100;
        check(busy_o == 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
        cyc = 0;
        unstable = 0;
        while (!done_o && cyc < 200) begin
            if (new_cs_o != prev_cs || new_ip_o != prev_ip) unstable++;
            if (!busy_o) unstable++;
            if (inject == 1 && cyc == 2) start_i = 1'b1;
            else start_i = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        if (cyc >= 200) begin
            check(1'b0, "R2 done timeout", 32'(cyc), 32'd200);
            return;
        end
        check(unstable == 0, "R6 handler outputs stable while running", 32'(unstable), 32'd0);
        check(hold_err == 0, "R4 request held until ack", 32'(hold_err), 32'd0);
        // expected transfers
        ea[0] = phys(ss, sp - 16'd2); ed[0] = fl; ew[0] = 1'b1;
        ea[1] = phys(ss, sp - 16'd4); ed[1] = cs; ew[1] = 1'b1;
        ea[2] = phys(ss, sp - 16'd6); ed[2] = ip; ew[2] = 1'b1;
        ea[3] = {10'd0, t, 2'b00};    ed[3] = mem_val({10'd0, t, 2'b00}); ew[3] = 1'b0;
        ea[4] = {10'd0, t, 2'b10};    ed[4] = mem_val({10'd0, t, 2'b10}); ew[4] = 1'b0;
        check(log_n == 5, "R3 R5 R9 transfer count", 32'(log_n), 32'd5);
        for (int k = 0; k < 5; k++) begin
            if (k < log_n) begin
                check(log_addr[k] == ea[k] && log_data[k] == ed[k] && log_we[k] == ew[k],
                      k < 3 ? "R3 push address/data" : "R5 vector read",
                      {log_we[k], 11'd0, log_addr[k]}, {ew[k], 11'd0, ea[k]});
            end
        end
        check(new_ip_o == ed[3], "R6 new IP", 32'(new_ip_o), 32'(ed[3]));
        check(new_cs_o == ed[4], "R6 new CS", 32'(new_cs_o), 32'(ed[4]));
        check(new_flags_o == (fl & 16'hFCFF), "R7 flags masked", 32'(new_flags_o), 32'(fl & 16'hFCFF));
        check(new_sp_o == sp - 16'd6, "R8 final SP", 32'(new_sp_o), 32'(sp - 16'd6));
        check(busy_o == 1'b1, "R2 busy in done cycle", 32'(busy_o), 32'd1);
        prev_cs = ed[4];
        prev_ip = ed[3];
        if (inject == 3) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!busy_o && !done_o && !mem_req_o, "R9 R2 idle after done",
              {29'd0, busy_o, done_o, mem_req_o}, 32'd0);
        @(negedge clk);
        check(!mem_req_o && log_n == 5, "R9 no extra request", 32'(log_n), 32'd5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !mem_req_o, "R1 reset control outputs",
              {29'd0, busy_o, done_o, mem_req_o}, 32'd0);
        check(new_cs_o == 0 && new_ip_o == 0 && new_flags_o == 0 && new_sp_o == 0,
              "R1 reset result outputs", 32'(new_cs_o | new_ip_o | new_flags_o | new_sp_o), 32'd0);
        rst_n = 1'b1;
        for (int t = 0; t < 256; t++) begin
            logic [15:0] ssv, spv;
            ssv = (t % 5 == 4) ? 16'hFFFF : 16'(t * 13 + 16'h0700);
            spv = (t < 3) ? 16'(t * 2) : 16'(16'hFFFE - t * 37);
            run_seq(8'(t), {8'(t), ~8'(t)}, 16'(t * 257), 16'(16'hF000 + t * 7),
                    ssv, spv, t % 3, t % 4);
        end
        run_seq(8'hFF, 16'hFFFF, 16'h1234, 16'h5678, 16'hFFFF, 16'h0000, 2, 3);
        run_seq(8'h00, 16'h0300, 16'h0000, 16'h0000, 16'h0000, 16'h0002, 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule